// File: doc/BRIEF.md
# Stretched Pulse Clock-Domain Crosser

This block moves isolated one-cycle event strobes from a fast source clock into a slower destination clock that has no phase relation to it. The default pairing is a 100 MHz source and a 50 MHz destination. Each accepted strobe is widened on the source side into a level that lasts a fixed number of source cycles. The level is carried across by a chain of destination-clocked flops. On the destination side, a registered rising-edge detector turns it back into a single destination-cycle strobe.

The synchronized level is also returned to the source domain through a second flop chain. The source side keeps a busy flag raised until three things have happened: the stretch has ended, the returned level has been seen high and then low, and a short guard count has elapsed. Only then can a new event be taken.

A strobe that arrives while busy is dropped and produces nothing downstream. The drop is recorded in a sticky overflow flag, so events are never silently merged. Crossing latency is two or three destination cycles, depending on where the first synchronizer flop catches the transition.

Top module: `pulseCrosser`

## Requirements
- R1: While either reset is applied and in the first cycle after it is released, `dstPulse`, `srcBusy` and `srcOverflow` are all 0.
- R2: Every accepted source event produces exactly one destination strobe, and that strobe is high for exactly one destination cycle.
- R3: The destination strobe rises on the third rising `dstClk` edge that follows the `srcClk` edge which accepted the event. It therefore appears more than two and at most three destination periods after that edge.
- R4: `srcBusy` is 1 in the source cycle after an event is accepted. It stays 1 until the destination strobe for that event has been issued and the returned level has gone low again.
- R5: A `srcPulse` sampled while `srcBusy` is 1 is dropped: it yields no destination strobe and does not extend the current event.
- R6: `srcOverflow` is set by a dropped event, stays set, and is cleared only by `srcRst`.
- R7: A `srcPulse` sampled in the first cycle in which `srcBusy` reads 0 is accepted.
- R8: `dstRst` clears the destination-side state, and events sent after it is released are delivered normally.
- R9: The stretched level stays high for exactly `STRETCH_CYCLES` source cycles (3 by default).
- R10: A series of accepted events with varied spacing is delivered in full and in order, with no extra strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRst | input | 1 | Synchronous active-high reset, source domain |
| srcPulse | input | 1 | One-cycle event strobe, source domain |
| dstClk | input | 1 | Destination domain clock |
| dstRst | input | 1 | Synchronous active-high reset, destination domain |
| dstPulse | output | 1 | One-cycle event strobe, destination domain |
| srcBusy | output | 1 | High while a previous event is still crossing |
| srcOverflow | output | 1 | Sticky flag: an event was dropped while busy |

## Verification
`srcBusy` and `srcOverflow` are registered and are due one source cycle after the strobe that changes them. The bench reads them at the next falling `srcClk` edge. The destination strobe is due on the third `dstClk` rising edge after the accepting source edge. For each accepted event, the driver queues the time of that source edge. The monitor samples `dstPulse` on falling `dstClk` edges and backs off half a period to recover the rising edge that produced it. It then requires the gap to lie above two and at or below three destination periods. Because the two clocks are phase-offset so that their edges never coincide, the expected cycle is unambiguous.

// File: rtl/pulseXingPkg.sv
`timescale 1ns/1ps
package pulseXingPkg;

  // Source-side sequencing of one event crossing
  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,   // ready for a new event
    XS_ACTIVE = 2'd1,   // stretching, waiting for returned level high
    XS_DRAIN  = 2'd2,   // waiting for returned level to fall
    XS_GUARD  = 2'd3    // margin before accepting again
  } xingState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startStretch;
  } ctlStrobes_t;

  // Observations from datapath to control
  typedef struct packed {
    logic stretchLevel;
    logic fbLevel;
  } pathStatus_t;

endpackage

// File: rtl/syncChain.sv
`timescale 1ns/1ps
module syncChain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dIn,
  output logic qOut
);
  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] stages;

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= {stages[DEPTH-2:0], dIn};
  end

  assign qOut = stages[DEPTH-1];
endmodule

// File: rtl/pulseXingPath.sv
`timescale 1ns/1ps
module pulseXingPath
  import pulseXingPkg::*;
#(
  parameter int STRETCH_CYCLES = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic        srcClk,
  input  logic        srcRst,
  input  logic        dstClk,
  input  logic        dstRst,
  input  ctlStrobes_t ctl,
  output pathStatus_t status,
  output logic        dstPulse
);
  localparam int CNT_W = (STRETCH_CYCLES > 2) ? $clog2(STRETCH_CYCLES) : 1;

  // Source side: widen one accepted strobe into a fixed-length level
  logic [CNT_W-1:0] stretchCnt;
  logic             stretchLevel;

  always_ff @(posedge srcClk) begin
    if (srcRst) begin
      stretchLevel <= 1'b0;
      stretchCnt   <= '0;
    end else if (ctl.startStretch) begin
      stretchLevel <= 1'b1;
      stretchCnt   <= CNT_W'(STRETCH_CYCLES - 1);
    end else if (stretchLevel) begin
      if (stretchCnt == '0) stretchLevel <= 1'b0;
      else                  stretchCnt   <= stretchCnt - 1'b1;
    end
  end

  // Forward crossing into the destination domain
  logic syncedLevel;
  syncChain #(.STAGES(SYNC_STAGES)) fwdSync (
    .clk (dstClk),
    .rst (dstRst),
    .dIn (stretchLevel),
    .qOut(syncedLevel)
  );

  // Registered rising-edge detector
  logic prevLevel;
  logic pulseReg;

  always_ff @(posedge dstClk) begin
    if (dstRst) begin
      prevLevel <= 1'b0;
      pulseReg  <= 1'b0;
    end else begin
      prevLevel <= syncedLevel;
      pulseReg  <= syncedLevel & ~prevLevel;
    end
  end

  assign dstPulse = pulseReg;

  // Return path so the source side knows when the level was seen
  logic fbLevel;
  syncChain #(.STAGES(SYNC_STAGES)) fbSync (
    .clk (srcClk),
    .rst (srcRst),
    .dIn (syncedLevel),
    .qOut(fbLevel)
  );

  assign status.stretchLevel = stretchLevel;
  assign status.fbLevel      = fbLevel;
endmodule

// File: rtl/pulseXingCtl.sv
`timescale 1ns/1ps
module pulseXingCtl
  import pulseXingPkg::*;
#(
  parameter int GUARD_CYCLES = 2
) (
  input  logic        srcClk,
  input  logic        srcRst,
  input  logic        srcPulse,
  input  pathStatus_t status,
  output ctlStrobes_t ctl,
  output logic        srcBusy,
  output logic        srcOverflow
);
  localparam int GW = (GUARD_CYCLES > 0) ? $clog2(GUARD_CYCLES + 1) : 1;

  xingState_t state, stateNext;
  logic       seenHigh;
  logic [GW-1:0] guardCnt;
  logic       overflowReg;

  always_comb begin
    stateNext = state;
    case (state)
      XS_IDLE:   if (srcPulse) stateNext = XS_ACTIVE;
      XS_ACTIVE: if (!status.stretchLevel && (seenHigh || status.fbLevel))
                   stateNext = XS_DRAIN;
      XS_DRAIN:  if (!status.fbLevel) stateNext = XS_GUARD;
      XS_GUARD:  if (guardCnt == '0) stateNext = XS_IDLE;
      default:   stateNext = XS_IDLE;
    endcase
  end

  always_comb begin
    ctl              = '0;
    ctl.startStretch = (state == XS_IDLE) && srcPulse;
  end

  always_ff @(posedge srcClk) begin
    if (srcRst) begin
      state       <= XS_IDLE;
      seenHigh    <= 1'b0;
      guardCnt    <= '0;
      overflowReg <= 1'b0;
    end else begin
      state <= stateNext;

      if (ctl.startStretch)                          seenHigh <= 1'b0;
      else if (state == XS_ACTIVE && status.fbLevel) seenHigh <= 1'b1;

      if (state == XS_DRAIN)                         guardCnt <= GW'(GUARD_CYCLES);
      else if (state == XS_GUARD && guardCnt != '0)  guardCnt <= guardCnt - 1'b1;

      if (srcPulse && state != XS_IDLE) overflowReg <= 1'b1;
    end
  end

  assign srcBusy     = (state != XS_IDLE);
  assign srcOverflow = overflowReg;
endmodule

// File: rtl/pulseCrosser.sv
`timescale 1ns/1ps
module pulseCrosser
  import pulseXingPkg::*;
#(
  parameter int STRETCH_CYCLES = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int GUARD_CYCLES   = 2
) (
  input  logic srcClk,
  input  logic srcRst,
  input  logic srcPulse,
  input  logic dstClk,
  input  logic dstRst,
  output logic dstPulse,
  output logic srcBusy,
  output logic srcOverflow
);
  ctlStrobes_t ctlBus;
  pathStatus_t pathStat;
  logic        stretchMon;

  pulseXingCtl #(.GUARD_CYCLES(GUARD_CYCLES)) ctrl (
    .srcClk     (srcClk),
    .srcRst     (srcRst),
    .srcPulse   (srcPulse),
    .status     (pathStat),
    .ctl        (ctlBus),
    .srcBusy    (srcBusy),
    .srcOverflow(srcOverflow)
  );

  pulseXingPath #(
    .STRETCH_CYCLES(STRETCH_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) path (
    .srcClk  (srcClk),
    .srcRst  (srcRst),
    .dstClk  (dstClk),
    .dstRst  (dstRst),
    .ctl     (ctlBus),
    .status  (pathStat),
    .dstPulse(dstPulse)
  );

  assign stretchMon = pathStat.stretchLevel;
endmodule

// File: rtl/pulseCrosserChecker.sv
`timescale 1ns/1ps
module pulseCrosserChecker #(
  parameter int STRETCH_CYCLES = 3
) (
  input logic srcClk,
  input logic srcRst,
  input logic srcPulse,
  input logic dstClk,
  input logic dstRst,
  input logic dstPulse,
  input logic srcBusy,
  input logic srcOverflow,
  input logic stretchLevel
);
  int highCount;

  always_ff @(posedge srcClk) begin
    if (srcRst)            highCount <= 0;
    else if (stretchLevel) highCount <= highCount + 1;
    else                   highCount <= 0;
  end

  // R2
  dst_pulse_width_chk: assert property (@(posedge dstClk) disable iff (dstRst)
    dstPulse |=> !dstPulse);

  // R4
  busy_on_accept_chk: assert property (@(posedge srcClk) disable iff (srcRst)
    (srcPulse && !srcBusy) |=> srcBusy);

  // R6
  overflow_sticky_chk: assert property (@(posedge srcClk) disable iff (srcRst)
    srcOverflow |=> srcOverflow);

  // R6
  overflow_cause_chk: assert property (@(posedge srcClk) disable iff (srcRst)
    $rose(srcOverflow) |-> $past(srcPulse && srcBusy));

  // R9
  stretch_width_chk: assert property (@(posedge srcClk) disable iff (srcRst)
    $fell(stretchLevel) |-> (highCount == STRETCH_CYCLES));
endmodule

bind pulseCrosser pulseCrosserChecker #(.STRETCH_CYCLES(STRETCH_CYCLES)) chk (
  .srcClk      (srcClk),
  .srcRst      (srcRst),
  .srcPulse    (srcPulse),
  .dstClk      (dstClk),
  .dstRst      (dstRst),
  .dstPulse    (dstPulse),
  .srcBusy     (srcBusy),
  .srcOverflow (srcOverflow),
  .stretchLevel(stretchMon)
);

// File: tb/pulseCrosser_test.sv
`timescale 1ns/1ps
module pulseCrosser_test;
  localparam int SRC_PERIOD = 10;
  localparam int DST_PERIOD = 20;

  logic srcClk = 1'b0;
  logic dstClk = 1'b0;
  logic srcRst = 1'b1;
  logic dstRst = 1'b1;
  logic srcPulse = 1'b0;
  logic dstPulse, srcBusy, srcOverflow;

  int checks = 0;
  int errors = 0;
  int acceptedCount = 0;
  int deliveredCount = 0;
  bit finished = 1'b0;
  logic prevSeen = 1'b0;
  longint expQ[$];

  pulseCrosser uut (
    .srcClk(srcClk), .srcRst(srcRst), .srcPulse(srcPulse),
    .dstClk(dstClk), .dstRst(dstRst), .dstPulse(dstPulse),
    .srcBusy(srcBusy), .srcOverflow(srcOverflow)
  );

  initial forever #(SRC_PERIOD/2) srcClk = ~srcClk;
  initial begin
    #2;
    forever #(DST_PERIOD/2) dstClk = ~dstClk;
  end

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: call just after a falling srcClk edge
  task automatic sendEvent(input string req);
    logic accepted;
    accepted = !srcBusy;
    srcPulse = 1'b1;
    if (accepted) begin
      expQ.push_back(longint'($time) + SRC_PERIOD/2);
      acceptedCount++;
    end
    @(negedge srcClk);
    srcPulse = 1'b0;
    if (accepted) checkBit({req, " busy after accept (R4)"}, srcBusy, 1'b1);
    else          checkBit({req, " overflow on drop (R6)"}, srcOverflow, 1'b1);
  endtask

  // Returns at the falling edge where busy is first seen low
  task automatic waitIdle(input string req);
    for (int i = 0; i < 500; i++) begin
      if (!srcBusy) return;
      @(negedge srcClk);
    end
    checkBit({req, " busy never cleared (R4)"}, srcBusy, 1'b0);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge dstClk);
      if (dstRst) begin
        prevSeen = 1'b0;
      end else begin
        if (dstPulse && prevSeen) begin
          checks++; errors++;
          $display("FAIL R2 pulse width actual 2+ cycles expected 1 at %0t", $time);
        end
        if (dstPulse && !prevSeen) begin
          deliveredCount++;
          checks++;
          if (expQ.size() == 0) begin
            errors++;
            $display("FAIL R5 unexpected strobe actual 1 expected 0 at %0t", $time);
          end else begin
            longint t0, d;
            t0 = expQ.pop_front();
            d = longint'($time) - DST_PERIOD/2 - t0;
            if (d <= 2*DST_PERIOD || d > 3*DST_PERIOD) begin
              errors++;
              $display("FAIL R3 latency actual %0d expected (%0d,%0d]",
                       d, 2*DST_PERIOD, 3*DST_PERIOD);
            end
          end
        end
        prevSeen = dstPulse;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge srcClk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge srcClk);
    checkBit("R1 dstPulse in reset", dstPulse, 1'b0);
    checkBit("R1 busy in reset", srcBusy, 1'b0);
    srcRst = 1'b0;
    dstRst = 1'b0;
    @(negedge srcClk);
    checkBit("R1 busy after reset", srcBusy, 1'b0);
    checkBit("R1 overflow after reset", srcOverflow, 1'b0);
    checkBit("R1 dstPulse after reset", dstPulse, 1'b0);

    // Single event
    sendEvent("R2 single");
    waitIdle("R2 single");
    checkInt("R4 strobe issued before busy drops", expQ.size(), 0);
    checkInt("R2 one strobe", deliveredCount, 1);

    // Event while busy is dropped
    repeat (3) @(negedge srcClk);
    sendEvent("R5 first");
    sendEvent("R5 dropped");
    waitIdle("R5");
    repeat (30) @(negedge srcClk);
    checkInt("R5 no strobe for dropped event", deliveredCount, acceptedCount);
    checkBit("R6 overflow sticky", srcOverflow, 1'b1);

    // Boundary: strobe in first idle cycle
    sendEvent("R7 prior");
    waitIdle("R7 prior");
    sendEvent("R7 boundary");
    waitIdle("R7");
    repeat (10) @(negedge srcClk);
    checkInt("R7 boundary delivered", deliveredCount, acceptedCount);

    // Source reset clears overflow
    srcRst = 1'b1;
    @(negedge srcClk);
    srcRst = 1'b0;
    @(negedge srcClk);
    checkBit("R6 overflow cleared by srcRst", srcOverflow, 1'b0);

    // Spaced series
    for (int i = 0; i < 5; i++) begin
      waitIdle("R10 series");
      repeat (i*3 + 1) @(negedge srcClk);
      sendEvent("R10 series");
    end
    waitIdle("R10 series");
    repeat (10) @(negedge srcClk);
    checkInt("R10 series delivered", deliveredCount, acceptedCount);
    checkBit("R6 overflow stays clear", srcOverflow, 1'b0);

    // Destination reset
    dstRst = 1'b1;
    repeat (3) @(negedge dstClk);
    checkBit("R8 dstPulse in dstRst", dstPulse, 1'b0);
    dstRst = 1'b0;
    @(negedge srcClk);
    sendEvent("R8 after dstRst");
    waitIdle("R8");
    repeat (10) @(negedge srcClk);
    checkInt("R8 delivered after dstRst", deliveredCount, acceptedCount);

    repeat (20) @(negedge srcClk);
    checkInt("R10 queue drained", expQ.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule